// File: doc/BRIEF.md
# Quad SPI NOR Flash Command Controller

This block is the bus master between a boot-and-update subsystem and an external serial NOR flash. A client places one command on a small request port: identify, quad-rate fast read of a byte range, page program, 4 KB sector erase, status read, status write, write-latch set or write-latch clear. The block converts it into chip-select, serial clock and four data lines, each data line with its own output-enable. Bytes read from the device leave on a byte stream with a one-cycle valid strobe. Bytes to be written are pulled from the client one at a time.

The block uses one fixed device profile: 24-bit addresses, a single dummy byte on quad reads, and a 256-byte page across 8192 pages. Commands that change the array or the status register get their own write-latch transaction first, with no client action. After a program or an erase the controller reads status until the busy bit clears, with a client-set limit on the number of reads. The serial clock is half the system clock, so one bit period (or one nibble period on four lines) takes two system cycles.

Top module: `qspi_flash_ctrl`

## Requirements
- R1: Command codes on `req_cmd` are 0 identify, 1 quad read, 2 program, 3 erase, 4 status read, 5 status write, 6 write-latch set, 7 write-latch clear. Their opcodes are 0x9F, 0xEB, 0x02, 0x20, 0x05, 0x01, 0x06, 0x04. Each opcode goes out MSB first on DQ0 alone, with `dq_oe` = 4'b0001.
- R2: Program and erase send a 3-byte address, MSB first, on DQ0 alone. Quad read sends its 3-byte address on DQ3..DQ0, high nibble first, with `dq_oe` = 4'b1111.
- R3: A quad read sends exactly one dummy byte (two clock periods) after the address. All four data lines are released (`dq_oe` = 0) for the dummy and data phases. Each byte is sampled from DQ3..DQ0, high nibble first, and `rd_valid` strobes the bytes in address order, `req_len` of them.
- R4: Identify returns 3 bytes with no dummy. Status read returns 1 byte. Both are sampled from DQ1 only.
- R5: Program, erase and status write are each preceded by a separate 0x06 transaction, with chip-select raised between the two.
- R6: After program or erase, status (0x05) is read repeatedly, and `done` pulses without `err` on the first read whose bit 0 (busy mask 0x01) is clear. Status reads made for this polling do not appear on `rd_valid`.
- R7: When `poll_limit` status reads have all reported busy, `done` pulses together with `err`. A limit of 0 behaves as 1.
- R8: A program with length 0, or with (address bits [7:0] + length) > 256, is rejected. `done` and `err` pulse together and no chip-select activity occurs. A program that ends exactly at the page end is accepted.
- R9: The clock idles low whenever chip-select is high (mode 0). Data is launched on the falling edge and sampled on the rising edge. Chip-select stays high at least 4 system cycles (2 clock periods) between transactions.
- R10: After reset, chip-select is high, the clock is low, all output-enables are 0, and `busy`, `done`, `err` and `rd_valid` are 0.
- R11: Program data and the status-write byte are taken from `wr_data` and sent MSB first on DQ0. `wr_take` pulses once after each byte is captured, and the client then presents the next byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, accepted while `busy` is low |
| req_cmd | input | 3 | Command code (R1) |
| req_addr | input | 24 | Byte address |
| req_len | input | LEN_W | Byte count for read and program |
| poll_limit | input | 16 | Maximum status reads after program or erase |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Qualifies `done`: rejected or timed out |
| wr_data | input | 8 | Next byte to write |
| wr_take | output | 1 | `wr_data` was captured |
| rd_data | output | 8 | Byte read from the device |
| rd_valid | output | 1 | `rd_data` is valid |
| spi_cs_n | output | 1 | Chip-select, active low |
| spi_sck | output | 1 | Serial clock |
| dq_o | output | 4 | Data line outputs |
| dq_oe | output | 4 | Per-line output enable |
| dq_i | input | 4 | Data line inputs |

## Verification
The bench goes after the points where the line width changes: a design that kept driving the bus through the dummy byte would clash with the device's first nibble, and one that sampled the wrong line on single-line reads would return inverted identify or status bytes. It checks that program, erase and status write reach the device with the write latch set, so a missing write-enable shows up as a refused command. It probes the page limit at both sides, where an off-by-one would either reject a legal tail-of-page program or put a wrapping program on the bus. It also checks that a device stuck busy ends in an error instead of a hang.

// File: rtl/qfc_pkg.sv
// Shared definitions for the quad SPI flash controller.
// Assumes one device profile: 24-bit addresses, 256-byte pages, busy in status bit 0.
package qfc_pkg;

    localparam int ADDR_W     = 24;
    localparam int PAGE_BYTES = 256;
    localparam logic [7:0] BUSY_MASK = 8'h01;

    typedef enum logic [2:0] {
        CMD_IDENT = 3'd0,
        CMD_QREAD = 3'd1,
        CMD_PROG  = 3'd2,
        CMD_ERASE = 3'd3,
        CMD_STRD  = 3'd4,
        CMD_STWR  = 3'd5,
        CMD_WLSET = 3'd6,
        CMD_WLCLR = 3'd7
    } cmd_e;

    localparam logic [7:0] OP_IDENT = 8'h9F;
    localparam logic [7:0] OP_QREAD = 8'hEB;
    localparam logic [7:0] OP_PROG  = 8'h02;
    localparam logic [7:0] OP_ERASE = 8'h20;
    localparam logic [7:0] OP_STRD  = 8'h05;
    localparam logic [7:0] OP_STWR  = 8'h01;
    localparam logic [7:0] OP_WLSET = 8'h06;
    localparam logic [7:0] OP_WLCLR = 8'h04;

    // One bus transaction, as handed from the sequencer to the bit engine.
    typedef struct packed {
        logic [7:0]        opc;
        logic              has_addr;
        logic [ADDR_W-1:0] addr;
        logic              quad;     // address, dummy and data on four lines
        logic              dummy;    // one dummy byte after the address
        logic              wr;       // data phase drives instead of samples
    } xfer_t;

endpackage

// File: rtl/qfc_bus_engine.sv
// Runs one serial flash transaction: opcode, optional address, optional dummy
// byte, then a data phase that is written or read.
// Assumes the clock divider is fixed at 2 (SCK toggles every system cycle),
// mode 0 timing, and that start only arrives while idle is high.
module qfc_bus_engine
    import qfc_pkg::*;
#(
    parameter int LEN_W   = 16,
    parameter int GAP_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  xfer_t            desc,
    input  logic [LEN_W-1:0] len,
    input  logic [7:0]       wr_data,
    output logic             wr_take,
    output logic [7:0]       rx_data,
    output logic             rx_valid,
    output logic             idle,
    output logic             done,
    output logic             cs_n,
    output logic             sck,
    output logic [3:0]       dq_o,
    output logic [3:0]       dq_oe,
    input  logic [3:0]       dq_i
);

    localparam int GAP_W = $clog2(GAP_CYC) + 1;

    typedef enum logic [1:0] {E_IDLE, E_RUN, E_GAP} est_e;
    typedef enum logic [1:0] {P_OPC, P_ADDR, P_DUM, P_DATA} ph_e;

    est_e             st;
    ph_e              ph;
    xfer_t            d;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] left;
    logic [7:0]       sr;
    logic [7:0]       rsr;
    logic [2:0]       bitc;
    logic [GAP_W-1:0] gapc;

    logic             wide;
    logic [2:0]       last;
    ph_e              n_ph;
    logic [LEN_W-1:0] n_left;
    logic             n_end;
    ph_e              tgt_ph;
    logic [LEN_W-1:0] tgt_left;
    logic [7:0]       tgt_byte;

    // Lines per clock and last bit slot of a byte for the current phase.
    always_comb begin
        wide = d.quad && (ph != P_OPC);
        last = wide ? 3'd1 : 3'd7;
    end

    // Phase that follows the current one when its last byte completes.
    always_comb begin
        n_ph   = ph;
        n_left = LEN_W'(1);
        n_end  = 1'b0;
        if (ph == P_OPC && d.has_addr) begin
            n_ph   = P_ADDR;
            n_left = LEN_W'(3);
        end else if ((ph == P_OPC || ph == P_ADDR) && d.dummy) begin
            n_ph = P_DUM;
        end else if (ph != P_DATA && len_q != '0) begin
            n_ph   = P_DATA;
            n_left = len_q;
        end else begin
            n_end = 1'b1;
        end
    end

    // Byte to load into the shift register at a byte boundary.
    always_comb begin
        if (left > LEN_W'(1)) begin
            tgt_ph   = ph;
            tgt_left = left - LEN_W'(1);
        end else begin
            tgt_ph   = n_ph;
            tgt_left = n_left;
        end
        case (tgt_ph)
            P_ADDR: begin
                case (tgt_left[1:0])
                    2'd3:    tgt_byte = d.addr[23:16];
                    2'd2:    tgt_byte = d.addr[15:8];
                    default: tgt_byte = d.addr[7:0];
                endcase
            end
            P_DATA:  tgt_byte = d.wr ? wr_data : 8'h00;
            default: tgt_byte = 8'h00;
        endcase
    end

    // Line drivers: single line for the opcode, released for dummy and reads.
    always_comb begin
        dq_o  = 4'b0000;
        dq_oe = 4'b0000;
        if (!cs_n) begin
            case (ph)
                P_OPC: begin
                    dq_o  = {3'b000, sr[7]};
                    dq_oe = 4'b0001;
                end
                P_ADDR: begin
                    dq_o  = d.quad ? sr[7:4] : {3'b000, sr[7]};
                    dq_oe = d.quad ? 4'b1111 : 4'b0001;
                end
                P_DATA: begin
                    if (d.wr) begin
                        dq_o  = d.quad ? sr[7:4] : {3'b000, sr[7]};
                        dq_oe = d.quad ? 4'b1111 : 4'b0001;
                    end
                end
                default: ;
            endcase
        end
    end

    // Transaction state, clock toggling, shifting and sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= E_IDLE;
            ph       <= P_OPC;
            d        <= '0;
            len_q    <= '0;
            left     <= '0;
            sr       <= '0;
            rsr      <= '0;
            bitc     <= '0;
            gapc     <= '0;
            cs_n     <= 1'b1;
            sck      <= 1'b0;
            rx_valid <= 1'b0;
            wr_take  <= 1'b0;
            done     <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            wr_take  <= 1'b0;
            done     <= 1'b0;
            case (st)
                E_IDLE: begin
                    if (start) begin
                        d     <= desc;
                        len_q <= len;
                        sr    <= desc.opc;
                        ph    <= P_OPC;
                        left  <= LEN_W'(1);
                        bitc  <= '0;
                        cs_n  <= 1'b0;
                        st    <= E_RUN;
                    end
                end
                E_RUN: begin
                    if (!sck) begin
                        sck <= 1'b1;
                        if (ph == P_DATA && !d.wr) begin
                            rsr <= wide ? {rsr[3:0], dq_i} : {rsr[6:0], dq_i[1]};
                            if (bitc == last) rx_valid <= 1'b1;
                        end
                    end else begin
                        sck <= 1'b0;
                        if (bitc != last) begin
                            bitc <= bitc + 3'd1;
                            sr   <= wide ? {sr[3:0], 4'b0000} : {sr[6:0], 1'b0};
                        end else begin
                            bitc <= '0;
                            if (left > LEN_W'(1) || !n_end) begin
                                ph   <= tgt_ph;
                                left <= tgt_left;
                                sr   <= tgt_byte;
                                if (tgt_ph == P_DATA && d.wr) wr_take <= 1'b1;
                            end else begin
                                cs_n <= 1'b1;
                                gapc <= '0;
                                st   <= E_GAP;
                            end
                        end
                    end
                end
                default: begin
                    if (gapc == GAP_W'(GAP_CYC - 1)) begin
                        done <= 1'b1;
                        st   <= E_IDLE;
                    end else begin
                        gapc <= gapc + GAP_W'(1);
                    end
                end
            endcase
        end
    end

    assign rx_data = rsr;
    assign idle    = (st == E_IDLE);

    // R9: clock parked low while deselected
    p_sck_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);

    // R9: chip-select held high across the inter-transaction gap
    p_cs_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> ##2 cs_n);

    // R3: every sampled byte arrives while the block drives no line
    p_rx_released_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (dq_oe == 4'b0000));

    // R1: the opcode phase uses DQ0 alone
    p_opc_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && ph == P_OPC) |-> (dq_oe == 4'b0001));

endmodule

// File: rtl/qfc_sequencer.sv
// Turns a client command into one or more bus transactions: write-latch set
// before modifying commands, the command itself, then status polling after
// program and erase. Rejects programs that would cross a page.
// Assumes the bus engine is idle whenever start is raised.
module qfc_sequencer
    import qfc_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [15:0]       poll_limit,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              start,
    output xfer_t             desc,
    output logic [LEN_W-1:0]  len,
    input  logic              eng_done,
    input  logic [7:0]        eng_rx_data,
    input  logic              eng_rx_valid,
    output logic              user_rx_valid
);

    localparam int PAGE_AW = $clog2(PAGE_BYTES);
    localparam int SUM_W   = LEN_W + 1;

    typedef enum logic [1:0] {S_IDLE, S_WREN, S_MAIN, S_POLL} sst_e;

    sst_e              st;
    cmd_e              cmd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  len_q;
    logic [15:0]       polls;
    logic [7:0]        stat;
    logic              reject;
    logic [SUM_W-1:0]  page_end;

    // Descriptor for the client's own transaction.
    function automatic xfer_t main_desc(cmd_e c, logic [ADDR_W-1:0] a);
        xfer_t x;
        x      = '0;
        x.addr = a;
        case (c)
            CMD_IDENT: x.opc = OP_IDENT;
            CMD_QREAD: begin
                x.opc = OP_QREAD; x.has_addr = 1'b1; x.quad = 1'b1; x.dummy = 1'b1;
            end
            CMD_PROG:  begin x.opc = OP_PROG;  x.has_addr = 1'b1; x.wr = 1'b1; end
            CMD_ERASE: begin x.opc = OP_ERASE; x.has_addr = 1'b1; end
            CMD_STRD:  x.opc = OP_STRD;
            CMD_STWR:  begin x.opc = OP_STWR; x.wr = 1'b1; end
            CMD_WLSET: x.opc = OP_WLSET;
            default:   x.opc = OP_WLCLR;
        endcase
        return x;
    endfunction

    // Data-phase length for the client's own transaction.
    function automatic logic [LEN_W-1:0] main_len(cmd_e c, logic [LEN_W-1:0] l);
        case (c)
            CMD_IDENT:          return LEN_W'(3);
            CMD_QREAD, CMD_PROG: return l;
            CMD_STRD, CMD_STWR: return LEN_W'(1);
            default:            return '0;
        endcase
    endfunction

    // Descriptor with only an opcode.
    function automatic xfer_t bare(logic [7:0] o);
        xfer_t x;
        x     = '0;
        x.opc = o;
        return x;
    endfunction

    // Page-crossing and empty-program check on the incoming request.
    always_comb begin
        page_end = SUM_W'(req_addr[PAGE_AW-1:0]) + SUM_W'(req_len);
        reject   = (cmd_e'(req_cmd) == CMD_PROG) &&
                   (req_len == '0 || page_end > SUM_W'(PAGE_BYTES));
    end

    // Command sequencing and poll accounting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= S_IDLE;
            cmd_q  <= CMD_IDENT;
            addr_q <= '0;
            len_q  <= '0;
            polls  <= '0;
            stat   <= '0;
            start  <= 1'b0;
            desc   <= '0;
            len    <= '0;
            done   <= 1'b0;
            err    <= 1'b0;
        end else begin
            start <= 1'b0;
            done  <= 1'b0;
            err   <= 1'b0;
            if (eng_rx_valid && st == S_POLL) stat <= eng_rx_data;
            case (st)
                S_IDLE: begin
                    if (req_valid) begin
                        cmd_q  <= cmd_e'(req_cmd);
                        addr_q <= req_addr;
                        len_q  <= req_len;
                        if (reject) begin
                            done <= 1'b1;
                            err  <= 1'b1;
                        end else if (cmd_e'(req_cmd) inside {CMD_PROG, CMD_ERASE, CMD_STWR}) begin
                            start <= 1'b1;
                            desc  <= bare(OP_WLSET);
                            len   <= '0;
                            st    <= S_WREN;
                        end else begin
                            start <= 1'b1;
                            desc  <= main_desc(cmd_e'(req_cmd), req_addr);
                            len   <= main_len(cmd_e'(req_cmd), req_len);
                            st    <= S_MAIN;
                        end
                    end
                end
                S_WREN: begin
                    if (eng_done) begin
                        start <= 1'b1;
                        desc  <= main_desc(cmd_q, addr_q);
                        len   <= main_len(cmd_q, len_q);
                        st    <= S_MAIN;
                    end
                end
                S_MAIN: begin
                    if (eng_done) begin
                        if (cmd_q == CMD_PROG || cmd_q == CMD_ERASE) begin
                            start <= 1'b1;
                            desc  <= bare(OP_STRD);
                            len   <= LEN_W'(1);
                            polls <= 16'd1;
                            st    <= S_POLL;
                        end else begin
                            done <= 1'b1;
                            st   <= S_IDLE;
                        end
                    end
                end
                default: begin
                    if (eng_done) begin
                        if ((stat & BUSY_MASK) == 8'h00) begin
                            done <= 1'b1;
                            st   <= S_IDLE;
                        end else if (polls >= poll_limit) begin
                            done <= 1'b1;
                            err  <= 1'b1;
                            st   <= S_IDLE;
                        end else begin
                            start <= 1'b1;
                            polls <= polls + 16'd1;
                        end
                    end
                end
            endcase
        end
    end

    assign busy          = (st != S_IDLE);
    assign user_rx_valid = eng_rx_valid && (st != S_POLL);

    // R8: a rejected program completes with an error on the next cycle
    p_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && req_valid && reject) |=> (done && err && !start));

    // R5: modifying opcodes are only launched right after the latch-set step
    p_wren_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (desc.opc == OP_PROG || desc.opc == OP_ERASE || desc.opc == OP_STWR))
            |-> ($past(st) == S_WREN));

    // R6: clean completion of program or erase only with busy clear
    p_done_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err && (cmd_q == CMD_PROG || cmd_q == CMD_ERASE))
            |-> ((stat & BUSY_MASK) == 8'h00));

endmodule

// File: rtl/qspi_flash_ctrl.sv
// Top of the quad SPI NOR flash command controller: a command sequencer
// feeding a single-transaction bus engine.
// Assumes the client holds req_* stable only for the cycle of req_valid.
module qspi_flash_ctrl #(
    parameter int LEN_W   = 16,
    parameter int GAP_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [2:0]       req_cmd,
    input  logic [23:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    input  logic [15:0]      poll_limit,
    output logic             busy,
    output logic             done,
    output logic             err,
    input  logic [7:0]       wr_data,
    output logic             wr_take,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             spi_cs_n,
    output logic             spi_sck,
    output logic [3:0]       dq_o,
    output logic [3:0]       dq_oe,
    input  logic [3:0]       dq_i
);

    qfc_pkg::xfer_t   x_desc;
    logic [LEN_W-1:0] x_len;
    logic             x_start;
    logic             x_done;
    logic             x_idle;
    logic             x_rx_valid;

    qfc_sequencer #(.LEN_W(LEN_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_cmd       (req_cmd),
        .req_addr      (req_addr),
        .req_len       (req_len),
        .poll_limit    (poll_limit),
        .busy          (busy),
        .done          (done),
        .err           (err),
        .start         (x_start),
        .desc          (x_desc),
        .len           (x_len),
        .eng_done      (x_done),
        .eng_rx_data   (rd_data),
        .eng_rx_valid  (x_rx_valid),
        .user_rx_valid (rd_valid)
    );

    qfc_bus_engine #(.LEN_W(LEN_W), .GAP_CYC(GAP_CYC)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (x_start),
        .desc     (x_desc),
        .len      (x_len),
        .wr_data  (wr_data),
        .wr_take  (wr_take),
        .rx_data  (rd_data),
        .rx_valid (x_rx_valid),
        .idle     (x_idle),
        .done     (x_done),
        .cs_n     (spi_cs_n),
        .sck      (spi_sck),
        .dq_o     (dq_o),
        .dq_oe    (dq_oe),
        .dq_i     (dq_i)
    );

    // R9: a new transaction never starts while the engine is busy
    p_start_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        x_start |-> x_idle);

endmodule

// File: tb/qspi_flash_ctrl_tb.sv
// Bench: a behavioural flash on the serial pins, a vector table walked by one
// loop, then directed tests for reset, page edge and poll timeout.
module qspi_flash_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_cmd = 3'd0;
    logic [23:0] req_addr = 24'd0;
    logic [15:0] req_len = 16'd0;
    logic [15:0] poll_limit = 16'd8;
    logic        busy, done, err, wr_take, rd_valid, spi_cs_n, spi_sck;
    logic [7:0]  wr_data, rd_data;
    logic [3:0]  dq_o, dq_oe;
    logic [3:0]  dq_i = 4'h0;

    always #10 clk = ~clk;

    qspi_flash_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_len(req_len), .poll_limit(poll_limit),
        .busy(busy), .done(done), .err(err), .wr_data(wr_data), .wr_take(wr_take),
        .rd_data(rd_data), .rd_valid(rd_valid), .spi_cs_n(spi_cs_n),
        .spi_sck(spi_sck), .dq_o(dq_o), .dq_oe(dq_oe), .dq_i(dq_i)
    );

    int checks = 0;
    int errors = 0;

    function automatic logic [7:0] pat(logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- client-side capture ----------------
    logic [7:0] wbuf [0:255];
    int widx = 0, wbase = 0;
    logic [7:0] rx_buf [0:255];
    int rx_n = 0;
    int done_n = 0;
    logic last_err = 1'b0;
    int cyc = 0;
    int hi_run = 0, gap_err = 0, idle_err = 0;
    logic seen_low = 1'b0;

    assign wr_data = wbuf[(widx - wbase) & 255];

    always @(posedge clk) begin
        cyc++;
        if (wr_take) widx++;
        if (rd_valid) begin rx_buf[rx_n & 255] = rd_data; rx_n++; end
        if (done) begin done_n++; last_err = err; end
        if (spi_cs_n && spi_sck) idle_err++;
        if (spi_cs_n) hi_run++;
        else begin
            if (seen_low && hi_run > 0 && hi_run < 4) gap_err++;
            if (hi_run > 0) seen_low = 1'b1;
            hi_run = 0;
        end
        if (cyc == 150000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- behavioural flash ----------------
    logic [7:0]  id_b [0:2];
    logic [7:0]  op_log [0:255];
    logic [23:0] fa_log [0:255];
    int n_ops = 0;
    logic [7:0]  pbuf [0:511];
    int prog_n = 0;
    int rn = 0;
    logic [7:0]  opc = 8'h00;
    logic [23:0] fa = 24'h0;
    logic [7:0]  stat_l = 8'h00, wsr = 8'h00, sr_val = 8'h00, pbyte = 8'h00;
    logic wel = 1'b0;
    int busy_cnt = 0, busy_n = 2;
    int contention = 0, line_err = 0, nowel_err = 0;

    initial begin id_b[0] = 8'hC2; id_b[1] = 8'h25; id_b[2] = 8'h37; end

    always @(negedge spi_cs_n) begin rn = 0; opc = 8'h00; fa = 24'h0; end

    always @(posedge spi_sck) if (!spi_cs_n) begin
        if (rn < 8) opc = {opc[6:0], dq_o[0]};
        else begin
            case (opc)
                8'hEB: if (rn < 14) begin
                    fa = {fa[19:0], dq_o};
                    if (dq_oe != 4'hF) line_err++;
                end else if (dq_oe != 4'h0) contention++;
                8'h02: if (rn < 32) begin
                    fa = {fa[22:0], dq_o[0]};
                    if (dq_oe != 4'h1) line_err++;
                end else begin
                    pbyte = {pbyte[6:0], dq_o[0]};
                    if ((rn - 32) % 8 == 7) begin pbuf[prog_n & 511] = pbyte; prog_n++; end
                end
                8'h20: if (rn < 32) begin
                    fa = {fa[22:0], dq_o[0]};
                    if (dq_oe != 4'h1) line_err++;
                end
                8'h01: wsr = {wsr[6:0], dq_o[0]};
                default: ;
            endcase
        end
        rn++;
        if (rn == 8 && opc == 8'h05) stat_l = {6'b0, wel, busy_cnt > 0};
    end

    always @(negedge spi_sck) if (!spi_cs_n && rn >= 8) begin
        int k;
        logic b;
        logic [7:0] by;
        k = rn - 8;
        case (opc)
            8'h9F: if (k < 24) begin b = id_b[k / 8][7 - k % 8]; dq_i = {2'b00, b, ~b}; end
            8'h05: begin b = stat_l[7 - k % 8]; dq_i = {2'b00, b, ~b}; end
            8'hEB: if (rn >= 16) begin
                k = rn - 16;
                by = pat(fa + 24'(k / 2));
                dq_i = (k % 2 == 0) ? by[7:4] : by[3:0];
                if (dq_oe != 4'h0) contention++;
            end
            default: ;
        endcase
    end

    always @(posedge spi_cs_n) if (rn > 0) begin
        op_log[n_ops & 255] = opc;
        fa_log[n_ops & 255] = fa;
        n_ops++;
        case (opc)
            8'h06: wel = 1'b1;
            8'h04: wel = 1'b0;
            8'h02, 8'h20: begin
                if (wel) busy_cnt = busy_n; else nowel_err++;
                wel = 1'b0;
            end
            8'h01: begin
                if (!wel) nowel_err++;
                sr_val = wsr;
                wel = 1'b0;
            end
            8'h05: if (stat_l[0] && busy_cnt > 0) busy_cnt--;
            default: ;
        endcase
    end

    // ---------------- stimulus ----------------
    int ops_base, rx_base, prog_base;

    task automatic do_req(logic [2:0] c, logic [23:0] a, logic [15:0] l);
        int d0;
        ops_base  = n_ops;
        rx_base   = rx_n;
        prog_base = prog_n;
        wbase     = widx;
        d0        = done_n;
        @(negedge clk);
        req_valid = 1'b1; req_cmd = c; req_addr = a; req_len = l;
        @(negedge clk);
        req_valid = 1'b0;
        while (done_n == d0) @(negedge clk);
        repeat (8) @(negedge clk);
    endtask

    typedef struct packed {
        logic [2:0]  cmd;
        logic [23:0] addr;
        logic [15:0] len;
        logic [7:0]  op0;
        logic [7:0]  op1;
        logic [3:0]  nops;
        logic [7:0]  nrx;
        logic [7:0]  rx0;
        logic        err;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 24'h000000, 16'd0,  8'h9F, 8'h00, 4'd1, 8'd3,  8'hC2, 1'b0},  // R4 ident
        '{3'd1, 24'h0123F0, 16'd20, 8'hEB, 8'h00, 4'd1, 8'd20, 8'hEF, 1'b0},  // R3 quad read
        '{3'd6, 24'h000000, 16'd0,  8'h06, 8'h00, 4'd1, 8'd0,  8'h00, 1'b0},  // R1 latch set
        '{3'd4, 24'h000000, 16'd0,  8'h05, 8'h00, 4'd1, 8'd1,  8'h02, 1'b0},  // R4 status read
        '{3'd7, 24'h000000, 16'd0,  8'h04, 8'h00, 4'd1, 8'd0,  8'h00, 1'b0},  // R1 latch clear
        '{3'd2, 24'h000210, 16'd16, 8'h06, 8'h02, 4'd5, 8'd0,  8'h00, 1'b0},  // R5 R6 program
        '{3'd3, 24'h045000, 16'd0,  8'h06, 8'h20, 4'd5, 8'd0,  8'h00, 1'b0},  // R5 R6 erase
        '{3'd5, 24'h000000, 16'd0,  8'h06, 8'h01, 4'd2, 8'd0,  8'h00, 1'b0},  // R5 status write
        '{3'd2, 24'h0000F8, 16'd9,  8'h00, 8'h00, 4'd0, 8'd0,  8'h00, 1'b1},  // R8 crosses page
        '{3'd2, 24'h000100, 16'd0,  8'h00, 8'h00, 4'd0, 8'd0,  8'h00, 1'b1}   // R8 empty program
    };

    initial begin
        for (int i = 0; i < 256; i++) wbuf[i] = 8'(8'hA0 + i * 7);
        repeat (5) @(negedge clk);
        // R10: reset state
        chk("R10", "cs_n", spi_cs_n, 1);
        chk("R10", "sck", spi_sck, 0);
        chk("R10", "dq_oe", dq_oe, 0);
        chk("R10", "busy/done/err/rd_valid", {busy, done, err, rd_valid}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            int bad;
            do_req(VECS[v].cmd, VECS[v].addr, VECS[v].len);
            chk("R8", $sformatf("row %0d err", v), last_err, VECS[v].err);
            chk("R1", $sformatf("row %0d transaction count", v), n_ops - ops_base, VECS[v].nops);
            if (VECS[v].nops >= 1)
                chk("R1", $sformatf("row %0d first opcode", v), op_log[ops_base & 255], VECS[v].op0);
            if (VECS[v].nops >= 2)
                chk("R5", $sformatf("row %0d second opcode", v), op_log[(ops_base + 1) & 255], VECS[v].op1);
            chk("R6", $sformatf("row %0d rd_valid count", v), rx_n - rx_base, VECS[v].nrx);
            if (VECS[v].nrx > 0)
                chk("R4", $sformatf("row %0d first byte", v), rx_buf[rx_base & 255], VECS[v].rx0);
            if (VECS[v].cmd == 3'd1) begin
                bad = 0;
                for (int j = 0; j < int'(VECS[v].nrx); j++)
                    if (rx_buf[(rx_base + j) & 255] != pat(VECS[v].addr + 24'(j))) bad++;
                chk("R3", "quad read byte mismatches", bad, 0);
                chk("R2", "quad read address", fa_log[ops_base & 255], VECS[v].addr);
            end
            if (VECS[v].cmd == 3'd2 && !VECS[v].err) begin
                bad = 0;
                for (int j = 0; j < int'(VECS[v].len); j++)
                    if (pbuf[(prog_base + j) & 511] != wbuf[j]) bad++;
                chk("R11", "program byte count", prog_n - prog_base, VECS[v].len);
                chk("R11", "program byte mismatches", bad, 0);
                chk("R2", "program address", fa_log[(ops_base + 1) & 255], VECS[v].addr);
                chk("R6", "poll opcode", op_log[(ops_base + 4) & 255], 8'h05);
            end
            if (VECS[v].cmd == 3'd3)
                chk("R2", "erase address", fa_log[(ops_base + 1) & 255], VECS[v].addr);
            if (VECS[v].cmd == 3'd5)
                chk("R11", "status byte written", sr_val, wbuf[0]);
        end

        // R8: program ending exactly at the page end is accepted
        busy_n = 1;
        do_req(3'd2, 24'h0000F8, 16'd8);
        chk("R8", "page-end program err", last_err, 0);
        chk("R6", "page-end program transactions", n_ops - ops_base, 4);
        chk("R11", "page-end program bytes", prog_n - prog_base, 8);

        // R7: device stays busy beyond the poll limit
        busy_n = 10;
        poll_limit = 16'd3;
        do_req(3'd3, 24'h002000, 16'd0);
        chk("R7", "timeout err", last_err, 1);
        chk("R7", "timeout transactions", n_ops - ops_base, 5);

        // Whole-run bus observations
        chk("R3", "drive clashes in dummy/data", contention, 0);
        chk("R2", "address line-width errors", line_err, 0);
        chk("R5", "modify without write latch", nowel_err, 0);
        chk("R9", "chip-select gap violations", gap_err, 0);
        chk("R9", "clock high while deselected", idle_err, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule